// File: doc/BRIEF.md
# Bit-Band Alias Bus Bridge

This bridge sits between a processor-side request port and a single-port word memory. It recognises two address windows. The first is the bit-band window, a block of ordinary words that the bridge forwards to the memory unchanged for both reads and writes. The second is the alias window, which starts at 0x22000000 and gives every single bit of the bit-band window a word-aligned address of its own. One backing word therefore covers 32 consecutive alias words.

A write to an alias address becomes a read-modify-write of the backing word done in hardware. Only the addressed bit changes, and the request port is held off until the write-back has been issued, so no other access can reach the memory between the read and the write. Software can set or clear one flag with a single store, and it needs no exclusive-access retry loop. A read from an alias address returns the addressed bit in bit 0. Any address outside both windows gets an error response and causes no memory access.

Top module: `bb_alias_bridge`

## Requirements
- R1: A read inside the bit-band window (base 0x20000000, 4 bytes per word) returns the backing word at index (addr-base)/4 with rsp_err low.
- R2: A write inside the bit-band window stores the full 32-bit write data in the backing word at index (addr-base)/4 and makes exactly one memory write.
- R3: A write to alias address A (A-0x22000000 = 4*k) changes only bit k%32 of backing word k/32. All other bits, and all other words, keep their values.
- R4: On an alias write only bit 0 of the write data is used. Bits 31:1 of the write data have no effect on the result.
- R5: An alias read returns the addressed bit in rsp_rdata[0], with rsp_rdata[31:1] zero, and makes no memory write.
- R6: From the cycle in which a request is accepted until its response, req_ready stays low. The write-back of an alias write is issued in the cycle right after its read, to the same memory address.
- R7: An address outside both windows, including the first address past the end of either window, gets rsp_valid with rsp_err high and causes no memory access.
- R8: After reset req_ready is high, and rsp_valid and mem_en are low.
- R9: Each accepted request gets exactly one response, no earlier than the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the accepted request |
| rsp_err | output | 1 | Address decoded to no window |
| rsp_rdata | output | 32 | Read data (word, or bit in bit 0) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | WORD_AW | Memory word index |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read strobe |

## Verification
In the same cycle, the data return of the alias read, the memory write-back and the response to the processor can all fall together, while a new request is already waiting at the port. The bench provokes this by holding req_valid high until the response arrives, so a request is always presented while the bridge is busy. It judges the outcome by counting the memory writes made in each transaction, by checking that req_ready stays low throughout, and by comparing every returned value and the final memory image with a shadow model.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_BAND_RD,
    OP_BAND_WR,
    OP_BIT_RD,
    OP_BIT_WR,
    OP_BAD
  } bb_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DATA,
    ST_ERR
  } bb_state_e;

  // byte offset of an address from a window base (wraps below base)
  function automatic logic [31:0] win_offset(input logic [31:0] addr,
                                             input logic [31:0] base);
    return addr - base;
  endfunction

  // alias byte offset -> bit position inside the backing word
  function automatic logic [4:0] alias_bitpos(input logic [31:0] off);
    return off[6:2];
  endfunction

endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter logic [31:0] BAND_BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          WORD_AW    = 8
) (
  input  logic [31:0]        addr,
  input  logic               write,
  output bb_op_e             op,
  output logic [WORD_AW-1:0] word_idx,
  output logic [4:0]         bit_pos
);

  localparam logic [31:0] BAND_BYTES  = 32'(4)   << WORD_AW;
  localparam logic [31:0] ALIAS_BYTES = 32'(128) << WORD_AW;

  logic [31:0] band_off;
  logic [31:0] alias_off;
  logic        in_band;
  logic        in_alias;

  assign band_off  = win_offset(addr, BAND_BASE);
  assign alias_off = win_offset(addr, ALIAS_BASE);
  assign in_band   = band_off  < BAND_BYTES;
  assign in_alias  = alias_off < ALIAS_BYTES;

  always_comb begin
    if (in_band)       op = write ? OP_BAND_WR : OP_BAND_RD;
    else if (in_alias) op = write ? OP_BIT_WR  : OP_BIT_RD;
    else               op = OP_BAD;
  end

  assign word_idx = in_band ? band_off[WORD_AW+1:2] : alias_off[WORD_AW+6:7];
  assign bit_pos  = alias_bitpos(alias_off);

endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane #(
  parameter int DW = 32,
  parameter int PW = $clog2(DW)
) (
  input  logic [DW-1:0] word_in,
  input  logic [PW-1:0] pos,
  input  logic          new_val,
  output logic [DW-1:0] merged,
  output logic [DW-1:0] picked
);

  logic [DW-1:0] sel;

  for (genvar i = 0; i < DW; i++) begin : g_lane
    assign sel[i]    = (pos == PW'(i));
    assign merged[i] = sel[i] ? new_val : word_in[i];
  end

  assign picked = {{(DW-1){1'b0}}, |(sel & word_in)};

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
#(
  parameter int WORD_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  bb_op_e             op_in,
  input  logic [WORD_AW-1:0] widx_in,
  input  logic [4:0]         bpos_in,
  input  logic [31:0]        wdata_in,
  output logic               req_ready,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [31:0]        rsp_rdata,
  output logic               acc_fire,
  output logic               acc_bad,
  output logic               rmw_rd,
  output logic               rmw_wr,
  output logic               bit_rd_done
);

  bb_state_e          state_q, state_d;
  bb_op_e             op_q;
  logic [WORD_AW-1:0] widx_q;
  logic [4:0]         bpos_q;
  logic [31:0]        wdata_q;
  logic [31:0]        merged;
  logic [31:0]        picked;

  bb_bit_lane #(.DW(32)) u_lane (
    .word_in (mem_rdata),
    .pos     (bpos_q),
    .new_val (wdata_q[0]),
    .merged  (merged),
    .picked  (picked)
  );

  assign acc_fire = req_valid && (state_q == ST_IDLE);
  assign acc_bad  = acc_fire && (op_in == OP_BAD);

  always_comb begin
    state_d     = state_q;
    req_ready   = 1'b0;
    mem_en      = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = widx_q;
    mem_wdata   = wdata_q;
    rsp_valid   = 1'b0;
    rsp_err     = 1'b0;
    rsp_rdata   = '0;
    rmw_rd      = 1'b0;
    rmw_wr      = 1'b0;
    bit_rd_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (acc_fire) state_d = (op_in == OP_BAD) ? ST_ERR : ST_ISSUE;
      end
      ST_ISSUE: begin
        mem_en = 1'b1;
        if (op_q == OP_BAND_WR) begin
          mem_we    = 1'b1;
          rsp_valid = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          rmw_rd  = (op_q == OP_BIT_WR);
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        rsp_valid = 1'b1;
        state_d   = ST_IDLE;
        if (op_q == OP_BAND_RD) rsp_rdata = mem_rdata;
        if (op_q == OP_BIT_RD) begin
          rsp_rdata   = picked;
          bit_rd_done = 1'b1;
        end
        if (op_q == OP_BIT_WR) begin
          mem_en    = 1'b1;
          mem_we    = 1'b1;
          mem_wdata = merged;
          rmw_wr    = 1'b1;
        end
      end
      ST_ERR: begin
        rsp_valid = 1'b1;
        rsp_err   = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      widx_q  <= '0;
      bpos_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (acc_fire) begin
        op_q    <= op_in;
        widx_q  <= widx_in;
        bpos_q  <= bpos_in;
        wdata_q <= wdata_in;
      end
    end
  end

endmodule

// File: rtl/bb_alias_bridge.sv
module bb_alias_bridge
  import bb_pkg::*;
#(
  parameter logic [31:0] BAND_BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          WORD_AW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [31:0]        req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [31:0]        rsp_rdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata
);

  bb_op_e             dec_op;
  logic [WORD_AW-1:0] dec_widx;
  logic [4:0]         dec_bpos;
  logic               acc_fire;
  logic               acc_bad;
  logic               rmw_rd;
  logic               rmw_wr;
  logic               bit_rd_done;

  bb_decode #(
    .BAND_BASE  (BAND_BASE),
    .ALIAS_BASE (ALIAS_BASE),
    .WORD_AW    (WORD_AW)
  ) u_dec (
    .addr     (req_addr),
    .write    (req_write),
    .op       (dec_op),
    .word_idx (dec_widx),
    .bit_pos  (dec_bpos)
  );

  bb_ctrl #(.WORD_AW(WORD_AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .op_in       (dec_op),
    .widx_in     (dec_widx),
    .bpos_in     (dec_bpos),
    .wdata_in    (req_wdata),
    .req_ready   (req_ready),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .acc_fire    (acc_fire),
    .acc_bad     (acc_bad),
    .rmw_rd      (rmw_rd),
    .rmw_wr      (rmw_wr),
    .bit_rd_done (bit_rd_done)
  );

endmodule

// File: rtl/bb_alias_bridge_chk.sv
module bb_alias_bridge_chk #(
  parameter int WORD_AW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [31:0]        rsp_rdata,
  input logic               mem_en,
  input logic               mem_we,
  input logic [WORD_AW-1:0] mem_addr,
  input logic               acc_fire,
  input logic               acc_bad,
  input logic               rmw_rd,
  input logic               rmw_wr,
  input logic               bit_rd_done
);

  logic busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (acc_fire)  busy_q <= 1'b1;
    else if (rsp_valid) busy_q <= 1'b0;
  end

  // R6
  ready_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !req_ready);

  // R6
  rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_rd |=> (rmw_wr && mem_en && mem_we && mem_addr == $past(mem_addr)));

  // R7
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> (rsp_valid && rsp_err && !mem_en));

  // R9
  rsp_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy_q);

  // R5
  bit_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_rd_done |-> (rsp_rdata[31:1] == 31'd0 && !mem_we));

endmodule

bind bb_alias_bridge bb_alias_bridge_chk #(.WORD_AW(WORD_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .rsp_rdata   (rsp_rdata),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .acc_fire    (acc_fire),
  .acc_bad     (acc_bad),
  .rmw_rd      (rmw_rd),
  .rmw_wr      (rmw_wr),
  .bit_rd_done (bit_rd_done)
);

// File: tb/tb_bb_alias_bridge.sv
`timescale 1ns/1ps
module tb_bb_alias_bridge;

  localparam int          AW    = 8;
  localparam int          NW    = 1 << AW;
  localparam logic [31:0] BBASE = 32'h2000_0000;
  localparam logic [31:0] ABASE = 32'h2200_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [31:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_err;
  logic [31:0]   rsp_rdata;
  logic          mem_en;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;

  logic [31:0] mem    [NW];
  logic [31:0] shadow [NW];
  int          wr_cnt = 0;
  int          acc_cnt = 0;
  int          n_tests = 0;
  int          n_fail  = 0;

  always #2 clk = ~clk;

  bb_alias_bridge #(.BAND_BASE(BBASE), .ALIAS_BASE(ABASE), .WORD_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      mem_rdata <= mem[mem_addr];
      acc_cnt <= acc_cnt + 1;
    end
  end

  initial begin
    #4000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 band, 1 alias, 2 outside
  function automatic int region(input logic [31:0] a);
    if (a >= BBASE && a < BBASE + NW*4)      return 0;
    if (a >= ABASE && a < ABASE + NW*128)    return 1;
    return 2;
  endfunction

  function automatic int alias_word(input logic [31:0] a);
    return int'((a - ABASE) / 128);
  endfunction

  function automatic int alias_bit(input logic [31:0] a);
    return int'(((a - ABASE) / 4) % 32);
  endfunction

  task automatic txn(input logic wr, input logic [31:0] a, input logic [31:0] wd);
    int w0, a0, w, b, reg_k;
    logic [31:0] exp_d;
    logic lock_ok;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    w0 = wr_cnt; a0 = acc_cnt;
    @(negedge clk);          // accepted at the edge just passed
    lock_ok = 1'b1;
    while (!rsp_valid) begin  // request held high while busy
      if (req_ready) lock_ok = 1'b0;
      @(negedge clk);
    end
    if (req_ready) lock_ok = 1'b0;
    reg_k = region(a);
    if (reg_k == 2) begin
      check("R7 err", {31'd0, rsp_err}, 32'd1);
    end else begin
      check("R7 no err", {31'd0, rsp_err}, 32'd0);
    end
    exp_d = 32'd0;
    if (reg_k == 0) begin
      w = int'((a - BBASE) / 4);
      if (!wr) exp_d = shadow[w];
      else shadow[w] = wd;
      if (!wr) check("R1 band read", rsp_rdata, exp_d);
    end else if (reg_k == 1) begin
      w = alias_word(a); b = alias_bit(a);
      if (!wr) check("R5 bit read", rsp_rdata, {31'd0, shadow[w][b]});
      else shadow[w][b] = wd[0];
    end
    check("R6 ready low", {31'd0, lock_ok}, 32'd1);
    req_valid = 1'b0;
    @(negedge clk);
    check(wr ? "R2/R3 one write" : "R5/R9 no write", wr_cnt - w0,
          (wr && reg_k != 2) ? 32'd1 : 32'd0);
    if (reg_k == 2) check("R7 no mem access", acc_cnt - a0, 32'd0);
  endtask

  task automatic read_back(input int w, input string req);
    txn(1'b0, BBASE + 32'(w*4), 32'd0);
    check(req, mem[w], shadow[w]);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      mem[i]    = 32'hA5A5_0000 ^ (i * 32'h0101_0307);
      shadow[i] = 32'hA5A5_0000 ^ (i * 32'h0101_0307);
    end
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    // R8
    check("R8 ready", {31'd0, req_ready}, 32'd1);
    check("R8 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R8 mem_en", {31'd0, mem_en}, 32'd0);
    rst_n = 1'b1;

    // R1 / R2 directed
    txn(1'b0, BBASE, 32'd0);
    txn(1'b1, BBASE + 32'(4*(NW-1)), 32'hDEAD_BEEF);
    read_back(NW-1, "R2 band write");
    // R3: top bit of last word, set then clear
    txn(1'b1, ABASE + 32'(((NW-1)*32 + 31)*4), 32'd1);
    read_back(NW-1, "R3 bit31 set");
    txn(1'b1, ABASE + 32'(((NW-1)*32 + 31)*4), 32'd0);
    read_back(NW-1, "R3 bit31 clear");
    // R4: upper data bits ignored
    txn(1'b1, BBASE + 32'd20, 32'h0000_0000);
    txn(1'b1, ABASE + 32'((5*32 + 7)*4), 32'hFFFF_FFFE);
    read_back(5, "R4 bit0 only (clear)");
    txn(1'b1, ABASE + 32'((5*32 + 9)*4), 32'h0000_0001);
    read_back(5, "R4 bit0 only (set)");
    check("R4 word5 value", shadow[5], 32'h0000_0200);
    // R5: bit 0 of word 0
    txn(1'b0, ABASE, 32'hFFFF_FFFF);
    // R7 boundaries
    txn(1'b0, BBASE + 32'(NW*4), 32'd0);
    txn(1'b1, ABASE + 32'(NW*128), 32'd1);
    txn(1'b1, 32'h1000_0000, 32'd1);
    txn(1'b0, BBASE - 32'd4, 32'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [31:0] a;
      k = int'($urandom_range(0, 9));
      if (k < 3)      a = BBASE + 32'($urandom_range(0, NW-1) * 4);
      else if (k < 9) a = ABASE + 32'($urandom_range(0, NW*32-1) * 4);
      else            a = $urandom();
      txn(1'($urandom_range(0, 1)), a, $urandom());
    end

    // R3: no other word disturbed
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < NW; i++) if (mem[i] !== shadow[i]) bad++;
      check("R3 memory image", 32'(bad), 32'd0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule